// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm Interrupt

This block keeps time as a 32-bit count of elapsed seconds, advanced by a one-cycle pulse that arrives once per second. A single compare register holds an alarm time. When the count steps onto that value, or when a periodic event is due, the block raises a core status flag and a system-level pending flag. The pending flag can be masked, and it drives the interrupt line.

Software reaches two register groups over a simple bus. Reads are combinational from the addressed register. Writes take effect on the clock edge that samples them.

Writes to the core group do not take effect at once. Each one starts a settling window of a parameterised length, and the value lands only when that window closes. Writes to the system group apply at once. The alarm is cleared in two layers. The core status bit is acknowledged by writing 1 to it. The system pending bit is cleared by writing 0 to it, which lets software use a read-modify-write.

Top module: `sec_rtc`

## Requirements
- R1: After reset the seconds count, alarm value, status, configuration and system register all read 0, and both `irqOut` and `busyOut` are low.
- R2: A bus write to a core register (group 0, byte offsets 0x00 status, 0x04 configuration, 0x0C time, 0x10 alarm) raises `busyOut` for SETTLE_CYCLES clock cycles. During that window reads still return the old value. The new value becomes visible in the cycle after the window closes.
- R3: A core write that arrives while `busyOut` is high is dropped and does not extend the settling window.
- R4: Each cycle with `tickPps` high adds one to the seconds count, wrapping from 0xFFFFFFFF to 0.
- R5: When a time write commits in the same cycle as a tick, the count takes the written value and is not incremented.
- R6: If the configuration alarm enable (bit 0) is set, a tick that advances the count to the alarm value sets status bit 0 and system pending bit 0 together. If the enable is clear, nothing is set.
- R7: Writing status with bit 0 at 1 clears status bit 0 once the write settles. Writing it with bit 0 at 0 leaves the bit unchanged. Status bit 1 always reads 0.
- R8: The system register (group 1, offset 0x08) applies writes without a settling window. Bits 2 and 3 are writable enables. Writing bit 0 as 0 clears pending bit 0, and writing it as 1 never sets it. Bit 1 always reads 0.
- R9: `irqOut` is high exactly while pending bit 0 and enable bit 2 are both set.
- R10: With configuration bit 1 (periodic enable) set, a periodic event sets status bit 0 and pending bit 0. If bit 2 is set, the event occurs on every tick. If bit 2 is clear, it occurs only on ticks whose new count has its low SLOW_LOG2 bits all zero.
- R11: If an event and a system write clearing pending bit 0 fall in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickPps | input | 1 | One-cycle pulse once per second |
| busCs | input | 1 | Bus access strobe |
| busWe | input | 1 | Write when high together with busCs |
| busGrp | input | 1 | Register group: 0 core, 1 system |
| busAddr | input | 5 | Byte offset within the group |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data of the addressed register, combinational |
| busyOut | output | 1 | Core write settling in progress |
| irqOut | output | 1 | Alarm interrupt request |

## Verification
Two pairs of functions can land on the same edge. The first pair is the commit of a time write and a seconds tick. The bench starts a time write and counts SETTLE_CYCLES-1 cycles, then pulses the tick so that it lines up with the commit edge. The result is judged by the count holding exactly the written value. The second pair is an alarm match and a system write clearing the pending bit. The bench drives both in one cycle and expects the pending bit and `irqOut` to remain set.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam logic [4:0] OFF_STATUS = 5'h00;
  localparam logic [4:0] OFF_CFG    = 5'h04;
  localparam logic [4:0] OFF_SYSIRQ = 5'h08;
  localparam logic [4:0] OFF_TIME   = 5'h0C;
  localparam logic [4:0] OFF_ALARM  = 5'h10;

  // Strobes from control to datapath
  typedef struct packed {
    logic        loadTime;
    logic        loadAlarm;
    logic        loadCfg;
    logic        ackStatus;
    logic        sysWrite;
    logic [2:0]  sysData;   // {enable1, enable0, pending0 keep}
    logic [31:0] commitData;
  } rtcStrobes_t;
endpackage

// File: rtl/sec_rtc_ctrl.sv
module sec_rtc_ctrl
  import sec_rtc_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCs,
  input  logic              busWe,
  input  logic              busGrp,
  input  logic [4:0]        busAddr,
  input  logic [31:0]       busWdata,
  output rtcStrobes_t       strobes,
  output logic              busyOut
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

  logic [CNT_W-1:0] settleCnt;
  logic [4:0]       pendAddr;
  logic [31:0]      pendData;
  logic             coreHit, accept, commit, addrMapped;

  always_comb begin
    addrMapped = (busAddr == OFF_STATUS) || (busAddr == OFF_CFG) ||
                 (busAddr == OFF_TIME)   || (busAddr == OFF_ALARM);
    coreHit = busCs && busWe && !busGrp && addrMapped;
    accept  = coreHit && (settleCnt == '0);
    commit  = (settleCnt == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
      pendAddr  <= '0;
      pendData  <= '0;
    end else if (accept) begin
      settleCnt <= CNT_W'(SETTLE_CYCLES);
      pendAddr  <= busAddr;
      pendData  <= busWdata;
    end else if (settleCnt != '0) begin
      settleCnt <= settleCnt - CNT_W'(1);
    end
  end

  always_comb begin
    strobes.loadTime   = commit && (pendAddr == OFF_TIME);
    strobes.loadAlarm  = commit && (pendAddr == OFF_ALARM);
    strobes.loadCfg    = commit && (pendAddr == OFF_CFG);
    strobes.ackStatus  = commit && (pendAddr == OFF_STATUS);
    strobes.commitData = pendData;
    strobes.sysWrite   = busCs && busWe && busGrp && (busAddr == OFF_SYSIRQ);
    strobes.sysData    = {busWdata[3], busWdata[2], busWdata[0]};
  end

  assign busyOut = (settleCnt != '0);

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyOut) |-> $past(busCs && busWe && !busGrp));

  // R3
  busy_no_extend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (settleCnt > CNT_W'(1) && coreHit) |=> (settleCnt == $past(settleCnt) - CNT_W'(1)));
endmodule

// File: rtl/sec_rtc_dp.sv
module sec_rtc_dp
  import sec_rtc_pkg::*;
#(
  parameter int SLOW_LOG2 = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickPps,
  input  rtcStrobes_t strobes,
  input  logic        busGrp,
  input  logic [4:0]  busAddr,
  output logic [31:0] busRdata,
  output logic        irqOut
);
  logic [31:0] timeCount, alarmVal, nextCount;
  logic        cfgAlarmEn, cfgFreqEn, cfgOneHz;
  logic        stAlarm, sysPend0, sysEn0, sysEn1;
  logic        advance, alarmHit, periodicHit, eventHit, slowDue;

  always_comb begin
    nextCount   = timeCount + 32'd1;
    advance     = tickPps && !strobes.loadTime;
    slowDue     = (nextCount[SLOW_LOG2-1:0] == '0);
    alarmHit    = advance && cfgAlarmEn && (nextCount == alarmVal);
    periodicHit = advance && cfgFreqEn && (cfgOneHz || slowDue);
    eventHit    = alarmHit || periodicHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeCount  <= '0;
      alarmVal   <= '0;
      cfgAlarmEn <= 1'b0;
      cfgFreqEn  <= 1'b0;
      cfgOneHz   <= 1'b0;
      stAlarm    <= 1'b0;
      sysPend0   <= 1'b0;
      sysEn0     <= 1'b0;
      sysEn1     <= 1'b0;
    end else begin
      if (strobes.loadTime)    timeCount <= strobes.commitData;
      else if (tickPps)        timeCount <= nextCount;
      if (strobes.loadAlarm)   alarmVal  <= strobes.commitData;
      if (strobes.loadCfg) begin
        cfgAlarmEn <= strobes.commitData[0];
        cfgFreqEn  <= strobes.commitData[1];
        cfgOneHz   <= strobes.commitData[2];
      end
      if (eventHit) stAlarm <= 1'b1;
      else if (strobes.ackStatus && strobes.commitData[0]) stAlarm <= 1'b0;
      if (eventHit) sysPend0 <= 1'b1;
      else if (strobes.sysWrite && !strobes.sysData[0]) sysPend0 <= 1'b0;
      if (strobes.sysWrite) begin
        sysEn0 <= strobes.sysData[1];
        sysEn1 <= strobes.sysData[2];
      end
    end
  end

  assign irqOut = sysPend0 && sysEn0;

  always_comb begin
    busRdata = '0;
    if (busGrp) begin
      if (busAddr == OFF_SYSIRQ) busRdata = {28'd0, sysEn1, sysEn0, 1'b0, sysPend0};
    end else begin
      unique case (busAddr)
        OFF_STATUS: busRdata = {31'd0, stAlarm};
        OFF_CFG:    busRdata = {29'd0, cfgOneHz, cfgFreqEn, cfgAlarmEn};
        OFF_TIME:   busRdata = timeCount;
        OFF_ALARM:  busRdata = alarmVal;
        default:    busRdata = '0;
      endcase
    end
  end

  // R4
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickPps && !strobes.loadTime) |=> (timeCount == $past(timeCount) + 32'd1));

  // R5
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadTime |=> (timeCount == $past(strobes.commitData)));

  // R6
  alarm_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickPps && !strobes.loadTime && cfgAlarmEn && (timeCount + 32'd1 == alarmVal))
      |=> (stAlarm && sysPend0));

  // R9
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> sysEn0);

  // R11
  pend_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (alarmHit && strobes.sysWrite) |=> sysPend0);
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8,
  parameter int SLOW_LOG2     = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickPps,
  input  logic        busCs,
  input  logic        busWe,
  input  logic        busGrp,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        busyOut,
  output logic        irqOut
);
  rtcStrobes_t strobes;

  sec_rtc_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .busCs(busCs), .busWe(busWe), .busGrp(busGrp),
    .busAddr(busAddr), .busWdata(busWdata), .strobes(strobes), .busyOut(busyOut)
  );

  sec_rtc_dp #(.SLOW_LOG2(SLOW_LOG2)) i_dp (
    .clk(clk), .rstN(rstN), .tickPps(tickPps), .strobes(strobes),
    .busGrp(busGrp), .busAddr(busAddr), .busRdata(busRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/test_sec_rtc.sv
module test_sec_rtc;
  localparam int S = 8;
  localparam logic [4:0] A_ST = 5'h00, A_CFG = 5'h04, A_SYS = 5'h08,
                         A_TIME = 5'h0C, A_ALM = 5'h10;

  logic clk = 1'b0, rstN = 1'b0, tickPps = 1'b0;
  logic busCs = 1'b0, busWe = 1'b0, busGrp = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic busyOut, irqOut;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sec_rtc #(.SETTLE_CYCLES(S), .SLOW_LOG2(2)) i_sec_rtc (
    .clk(clk), .rstN(rstN), .tickPps(tickPps), .busCs(busCs), .busWe(busWe),
    .busGrp(busGrp), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busyOut(busyOut), .irqOut(irqOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(logic grp, logic [4:0] addr, output logic [31:0] d);
    busGrp = grp; busAddr = addr; #1; d = busRdata;
  endtask

  task automatic chkReg(string tag, logic grp, logic [4:0] addr, logic [31:0] exp);
    logic [31:0] d;
    rd(grp, addr, d);
    check(tag, d, exp);
  endtask

  task automatic wr(logic grp, logic [4:0] addr, logic [31:0] d);
    @(negedge clk);
    busCs = 1; busWe = 1; busGrp = grp; busAddr = addr; busWdata = d;
    @(negedge clk);
    busCs = 0; busWe = 0;
  endtask

  task automatic wrSettled(logic [4:0] addr, logic [31:0] d);
    wr(0, addr, d);
    repeat (S) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); tickPps = 1;
    @(negedge clk); tickPps = 0;
  endtask

  task automatic testReset();
    chkReg("R1 time", 0, A_TIME, 0);
    chkReg("R1 alarm", 0, A_ALM, 0);
    chkReg("R1 status", 0, A_ST, 0);
    chkReg("R1 cfg", 0, A_CFG, 0);
    chkReg("R1 sys", 1, A_SYS, 0);
    check("R1 irq", irqOut, 0);
    check("R1 busy", busyOut, 0);
  endtask

  task automatic testSettle();
    wr(0, A_TIME, 32'd77);
    check("R2 busy after write", busyOut, 1);
    repeat (S - 1) @(negedge clk);
    chkReg("R2 old value in window", 0, A_TIME, 0);
    check("R2 busy last cycle", busyOut, 1);
    @(negedge clk);
    chkReg("R2 new value visible", 0, A_TIME, 32'd77);
    check("R2 busy cleared", busyOut, 0);
  endtask

  task automatic testCount();
    wrSettled(A_TIME, 32'hFFFF_FFFE);
    tick();
    chkReg("R4 increment", 0, A_TIME, 32'hFFFF_FFFF);
    tick();
    chkReg("R4 wrap", 0, A_TIME, 0);
  endtask

  task automatic testLoadVsTick();
    wr(0, A_TIME, 32'd50);
    repeat (S - 2) @(negedge clk);
    tick();
    chkReg("R5 load beats tick", 0, A_TIME, 32'd50);
  endtask

  task automatic testDrop();
    wr(0, A_ALM, 32'd200);
    wr(0, A_ALM, 32'd300);
    repeat (S - 2) @(negedge clk);
    check("R3 window not extended", busyOut, 0);
    chkReg("R3 busy write dropped", 0, A_ALM, 32'd200);
  endtask

  task automatic testAlarm();
    wrSettled(A_ALM, 32'd1000);
    wrSettled(A_CFG, 32'd1);
    wr(1, A_SYS, 32'h4);
    wrSettled(A_TIME, 32'd998);
    tick();
    chkReg("R6 no early flag", 0, A_ST, 0);
    check("R9 no early irq", irqOut, 0);
    tick();
    chkReg("R6 status set", 0, A_ST, 1);
    chkReg("R6 pending set", 1, A_SYS, 32'h5);
    check("R9 irq on", irqOut, 1);
    wrSettled(A_ST, 32'd0);
    chkReg("R7 write 0 keeps", 0, A_ST, 1);
    wrSettled(A_ST, 32'd3);
    chkReg("R7 write 1 clears", 0, A_ST, 0);
    check("R9 irq follows pending", irqOut, 1);
    wr(1, A_SYS, 32'h5);
    chkReg("R8 write 1 keeps pending", 1, A_SYS, 32'h5);
    wr(1, A_SYS, 32'h4);
    chkReg("R8 write 0 clears pending", 1, A_SYS, 32'h4);
    check("R9 irq off", irqOut, 0);
    wr(1, A_SYS, 32'h1);
    chkReg("R8 write 1 never sets", 1, A_SYS, 32'h0);
  endtask

  task automatic testMask();
    wrSettled(A_TIME, 32'd999);
    tick();
    chkReg("R9 pending masked", 1, A_SYS, 32'h1);
    check("R9 masked irq low", irqOut, 0);
    wr(1, A_SYS, 32'h5);
    check("R9 unmask raises irq", irqOut, 1);
    wr(1, A_SYS, 32'h8);
    chkReg("R8 enable1 writable", 1, A_SYS, 32'h8);
    check("R9 enable1 alone no irq", irqOut, 0);
    wrSettled(A_CFG, 32'd0);
    wrSettled(A_ST, 32'd1);
    wrSettled(A_TIME, 32'd999);
    tick();
    chkReg("R6 disabled no flag", 0, A_ST, 0);
  endtask

  task automatic testPeriodic();
    wrSettled(A_CFG, 32'd6);
    tick();
    chkReg("R10 every tick", 0, A_ST, 1);
    wrSettled(A_CFG, 32'd2);
    wrSettled(A_ST, 32'd1);
    wrSettled(A_TIME, 32'd5);
    tick();
    chkReg("R10 slow skip 6", 0, A_ST, 0);
    tick();
    chkReg("R10 slow skip 7", 0, A_ST, 0);
    tick();
    chkReg("R10 slow fire 8", 0, A_ST, 1);
  endtask

  task automatic testCollide();
    wrSettled(A_CFG, 32'd1);
    wrSettled(A_ST, 32'd1);
    wr(1, A_SYS, 32'h4);
    wrSettled(A_TIME, 32'd999);
    @(negedge clk);
    tickPps = 1; busCs = 1; busWe = 1; busGrp = 1; busAddr = A_SYS; busWdata = 32'h4;
    @(negedge clk);
    tickPps = 0; busCs = 0; busWe = 0;
    chkReg("R11 set wins over clear", 1, A_SYS, 32'h5);
    check("R11 irq stays", irqOut, 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testSettle();
    testCount();
    testLoadVsTick();
    testDrop();
    testAlarm();
    testMask();
    testPeriodic();
    testCollide();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule